// File: doc/BRIEF.md
# Per-Byte Transfer Request Pacer

This block paces sector data between a disk controller and a CPU one byte at a time. When a transfer starts, it offers a byte by raising DRQ. It drops DRQ as soon as the CPU moves that byte through the data register. The next byte is offered only at the start of the next byte slot. As a result, every byte gives a fresh DRQ edge, separated from the previous one by a guaranteed low time. The CPU can therefore sleep on an edge-triggered interrupt and wake once per byte.

An interrupt flag, like the one in a peripheral adapter, captures the chosen DRQ edge. The flag stays set until the CPU reads the adapter's data port. It reaches the interrupt pin only while the enable input is high. If the CPU lets a whole byte slot pass without taking the byte, the block sets a sticky lost-data flag and moves on to the next byte. After the last byte of the sector, DRQ stays low and a one-cycle completion pulse is issued.

Timing: one slot lasts `CLK_MHZ*BYTE_US` clock cycles. If the transfer starts at clock edge k, DRQ for byte b rises at edge k+1+GAP_CYCLES+b*SLOT. It stays high at most until the last cycle of its slot.

Top module: `drq_byte_pacer`

## Requirements
- R1: After reset, drq, irq, lost_data and sector_done are all low and no transfer is in progress.
- R2: A start taken while idle opens a transfer of SECTOR_BYTES (default 256) bytes. DRQ for byte b rises exactly GAP_CYCLES+1+b*SLOT cycles after the start cycle, once per byte.
- R3: With xfer_write=0 (read), a data_rd pulse while DRQ is high makes DRQ low on the next cycle, and a data_wr pulse has no effect on DRQ.
- R4: With xfer_write=1 (write), a data_wr pulse while DRQ is high makes DRQ low on the next cycle, and a data_rd pulse has no effect on DRQ.
- R5: Between two consecutive bytes DRQ is low for at least GAP_CYCLES cycles, and it is never held high from one byte into the next.
- R6: The interrupt flag sets one cycle after a DRQ edge of the selected kind: rising when edge_fall=0, falling when edge_fall=1. An edge of the other kind does not set it.
- R7: A port_rd pulse clears the flag on the next cycle. An edge in the same cycle takes priority and sets it.
- R8: irq equals the flag ANDed with irq_en. Lowering irq_en hides the flag without clearing it.
- R9: If DRQ is still high in the last cycle of its slot, DRQ drops and lost_data sets. A take in that last cycle is still on time. lost_data stays set until the next accepted start, and the following byte is still offered.
- R10: When the last byte is taken or missed, sector_done is high for exactly one cycle (the cycle after) and DRQ stays low from then on.
- R11: A start pulse during a transfer is ignored: direction, byte count and slot cadence are unchanged.
- R12: data_rd and data_wr pulses while DRQ is low are ignored and do not count as bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | One-cycle request to begin a sector transfer |
| xfer_write | input | 1 | Direction at start: 0 read, 1 write |
| data_rd | input | 1 | CPU read strobe of the controller data register |
| data_wr | input | 1 | CPU write strobe of the controller data register |
| port_rd | input | 1 | CPU read strobe of the adapter data port (clears flag) |
| irq_en | input | 1 | Interrupt output enable |
| edge_fall | input | 1 | Edge select: 0 rising, 1 falling |
| drq | output | 1 | Per-byte data request |
| irq | output | 1 | Interrupt request (flag AND enable) |
| lost_data | output | 1 | Sticky flag for a byte missed by the CPU |
| sector_done | output | 1 | One-cycle pulse after the final byte |

## Verification
A wrong slot counter moves a DRQ rise away from its computed cycle. That shows up at the first byte of the sector, or after at most one slot. A remaining-byte count that is off, or a stray strobe that is wrongly counted, moves sector_done away from the cycle after byte 255. A start that is wrongly accepted resets the cadence, so every later DRQ rise lands in the wrong cycle. A flag stuck in the wrong state appears on irq one cycle after the next DRQ edge or port read. A lost_data bit that fails to stick is seen at the next byte taken.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    typedef enum logic {
        XFER_READ  = 1'b0,
        XFER_WRITE = 1'b1
    } xfer_dir_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    // Registered state of the interrupt edge flag.
    typedef struct packed {
        logic prev;
        logic flag;
    } flag_state_s;

endpackage

// File: rtl/pacer_slot_timer.sv
module pacer_slot_timer #(
    parameter int SLOT_CYCLES = 1600,
    parameter int RAISE_AT    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic raise_o,
    output logic slot_end_o
);
    localparam int CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST  = CW'(SLOT_CYCLES - 1);
    localparam logic [CW-1:0] RAISE = CW'(RAISE_AT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign raise_o    = run_i && (tmr_q.cnt == RAISE);
    assign slot_end_o = run_i && (tmr_q.cnt == LAST);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tmr_q.cnt == '0)); // R2

endmodule

// File: rtl/pacer_sequencer.sv
module pacer_sequencer
    import pacer_pkg::*;
#(
    parameter int SECTOR_BYTES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic write_i,
    input  logic cpu_rd_i,
    input  logic cpu_wr_i,
    input  logic raise_i,
    input  logic slot_end_i,
    output logic busy_o,
    output logic drq_o,
    output logic lost_o,
    output logic done_o
);
    localparam int BW = $clog2(SECTOR_BYTES + 1);
    localparam logic [BW-1:0] FULL = BW'(SECTOR_BYTES);
    localparam logic [BW-1:0] ONE  = BW'(1);

    typedef struct packed {
        logic          busy;
        xfer_dir_e     dir;
        logic [BW-1:0] left;
        logic          drq;
        logic          lost;
        logic          done;
    } seq_s;

    seq_s seq_d, seq_q;
    logic take, miss, accept;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        take   = seq_q.drq && ((seq_q.dir == XFER_READ) ? cpu_rd_i : cpu_wr_i);
        miss   = seq_q.drq && slot_end_i && !take;
        accept = start_i && !seq_q.busy;

        if (!seq_q.busy) begin
            if (start_i) begin
                seq_d.busy = 1'b1;
                seq_d.dir  = write_i ? XFER_WRITE : XFER_READ;
                seq_d.left = FULL;
                seq_d.lost = 1'b0;
                seq_d.drq  = 1'b0;
            end
        end else if (take || miss) begin
            seq_d.drq  = 1'b0;
            seq_d.left = seq_q.left - ONE;
            if (miss) begin
                seq_d.lost = 1'b1;
            end
            if (seq_q.left == ONE) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
            end
        end else if (raise_i && !seq_q.drq) begin
            seq_d.drq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = seq_q.busy;
    assign drq_o  = seq_q.drq;
    assign lost_o = seq_q.lost;
    assign done_o = seq_q.done;

    AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !seq_q.drq); // R3
    AST_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.drq) |=> !seq_q.drq); // R5
    AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.lost && !accept) |=> seq_q.lost); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> (!seq_q.drq && !seq_q.busy)); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && start_i) |=> $stable(seq_q.dir)); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.left <= FULL); // R2

endmodule

// File: rtl/pacer_edge_flag.sv
module pacer_edge_flag
    import pacer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drq_i,
    input  logic fall_sel_i,
    input  logic port_rd_i,
    input  logic en_i,
    output logic irq_o
);
    flag_state_s fs_d, fs_q;
    edge_kind_e  kind;
    logic        hit;

    always_comb begin
        kind = fall_sel_i ? EDGE_FALL : EDGE_RISE;
        hit  = (kind == EDGE_FALL) ? (fs_q.prev && !drq_i)
                                   : (!fs_q.prev && drq_i);
        fs_d      = fs_q;
        fs_d.prev = drq_i;
        if (hit) begin
            fs_d.flag = 1'b1;
        end else if (port_rd_i) begin
            fs_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign irq_o = fs_q.flag && en_i;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> fs_q.flag); // R6
    AST_PORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_q.flag && port_rd_i && !hit) |=> !fs_q.flag); // R7

endmodule

// File: rtl/drq_byte_pacer.sv
module drq_byte_pacer #(
    parameter int CLK_MHZ      = 50,
    parameter int BYTE_US      = 32,
    parameter int GAP_CYCLES   = 8,
    parameter int SECTOR_BYTES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start,
    input  logic xfer_write,
    input  logic data_rd,
    input  logic data_wr,
    input  logic port_rd,
    input  logic irq_en,
    input  logic edge_fall,
    output logic drq,
    output logic irq,
    output logic lost_data,
    output logic sector_done
);
    localparam int SLOT    = CLK_MHZ * BYTE_US;
    localparam int GAP_EFF = (GAP_CYCLES < 2) ? 2 : GAP_CYCLES;

    logic busy, raise, slot_end;

    pacer_slot_timer #(
        .SLOT_CYCLES(SLOT),
        .RAISE_AT   (GAP_EFF - 1)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .raise_o   (raise),
        .slot_end_o(slot_end)
    );

    pacer_sequencer #(
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (xfer_start),
        .write_i   (xfer_write),
        .cpu_rd_i  (data_rd),
        .cpu_wr_i  (data_wr),
        .raise_i   (raise),
        .slot_end_i(slot_end),
        .busy_o    (busy),
        .drq_o     (drq),
        .lost_o    (lost_data),
        .done_o    (sector_done)
    );

    pacer_edge_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .drq_i     (drq),
        .fall_sel_i(edge_fall),
        .port_rd_i (port_rd),
        .en_i      (irq_en),
        .irq_o     (irq)
    );

    AST_IDLE_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sector_done) |-> !drq); // R1
    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !drq && !raise) |=> !drq); // R12

endmodule

// File: tb/sim_drq_byte_pacer.sv
module sim_drq_byte_pacer;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ  = 1;
    localparam int US   = 12;
    localparam int SLOT = MHZ * US;
    localparam int GAP  = 4;
    localparam int NB   = 256;

    localparam int S_DRQ  = 0;
    localparam int S_IRQ  = 1;
    localparam int S_LOST = 2;
    localparam int S_EOS  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_start = 1'b0, xfer_write = 1'b0, data_rd = 1'b0, data_wr = 1'b0;
    logic port_rd = 1'b0, irq_en = 1'b0, edge_fall = 1'b0;
    logic drq, irq, lost_data, sector_done;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    at;
        int    sig;
        int    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    drq_byte_pacer #(
        .CLK_MHZ(MHZ), .BYTE_US(US), .GAP_CYCLES(GAP), .SECTOR_BYTES(NB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
        .data_rd(data_rd), .data_wr(data_wr), .port_rd(port_rd), .irq_en(irq_en),
        .edge_fall(edge_fall), .drq(drq), .irq(irq), .lost_data(lost_data),
        .sector_done(sector_done)
    );

    function automatic int sig_now(int s);
        case (s)
            S_DRQ:   return int'(drq);
            S_IRQ:   return int'(irq);
            S_LOST:  return int'(lost_data);
            default: return int'(sector_done);
        endcase
    endfunction

    task automatic push(int at, int s, int v, string tag);
        exp_t e;
        e.at = at; e.sig = s; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pops expectations due in this cycle and compares.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
                n_chk++;
                if (sb[i].at < cyc || sig_now(sb[i].sig) != sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s sig%0d cyc %0d: got %0d expected %0d",
                             sb[i].tag, sb[i].sig, cyc, sig_now(sb[i].sig), sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    // Advance to cycle c (inputs change 2 time units after the edge); pulses end.
    task automatic wait_until(int c);
        while (cyc != c) begin
            @(posedge clk);
            #2;
            xfer_start = 1'b0; data_rd = 1'b0; data_wr = 1'b0; port_rd = 1'b0;
        end
    endtask

    // mode 0: read, rising edge; mode 1: write, falling edge, mask; mode 2: lost bytes
    task automatic run_sector(int mode);
        int k;
        bit wr;
        wr = (mode == 1);
        k = cyc;
        xfer_write = wr; edge_fall = (mode == 1); irq_en = 1'b1; xfer_start = 1'b1;
        push(k + 1, S_LOST, 0, "R9 cleared by start");
        for (int b = 0; b < NB; b++) begin
            int r;
            r = k + 1 + GAP + b * SLOT;
            wait_until(r - 2);
            data_rd = 1'b1; data_wr = 1'b1;               // R12 stray strobes
            wait_until(r - 1);
            push(r - 1, S_DRQ, 0, "R5 gap low");
            wait_until(r);
            push(r, S_DRQ, 1, "R2 cadence");
            if (mode != 2) begin
                if (wr) data_rd = 1'b1; else data_wr = 1'b1;
                if (mode == 0 && b == 5) begin
                    xfer_start = 1'b1; xfer_write = 1'b1;  // R11 busy start
                end
                wait_until(r + 1);
                push(r + 1, S_DRQ, 1, wr ? "R4 rd ignored" : "R3 wr ignored");
                push(r + 1, S_IRQ, (mode == 0) ? 1 : 0, "R6 edge select");
                wait_until(r + 2);
                if (wr) data_wr = 1'b1; else data_rd = 1'b1;
                wait_until(r + 3);
                push(r + 3, S_DRQ, 0, wr ? "R4 take" : "R3 take");
                push(r + 3, S_EOS, (b == NB - 1) ? 1 : 0, "R10 done pulse");
                if (b == NB - 1) push(r + 4, S_EOS, 0, "R10 one cycle");
                if (mode == 0) begin
                    push(r + 3, S_IRQ, 1, "R6 flag held");
                    port_rd = 1'b1;
                    wait_until(r + 4);
                    push(r + 4, S_IRQ, 0, "R7 port clear");
                end else begin
                    irq_en = 1'b0;
                    wait_until(r + 4);
                    push(r + 4, S_IRQ, 0, "R8 masked");
                    wait_until(r + 5);
                    irq_en = 1'b1;
                    push(r + 5, S_IRQ, 1, "R8 flag kept");
                    wait_until(r + 6);
                    port_rd = 1'b1;
                    wait_until(r + 7);
                    push(r + 7, S_IRQ, 0, "R7 port clear");
                end
            end else begin
                wait_until(r + 1);
                push(r + 1, S_IRQ, 1, "R6 rise sets");
                port_rd = 1'b1;
                if (b == 1) begin
                    wait_until(r + 7);
                    push(r + 7, S_DRQ, 1, "R9 still offered");
                    data_rd = 1'b1;
                    wait_until(r + 8);
                    push(r + 8, S_DRQ, 0, "R9 late take");
                    push(r + 8, S_LOST, 0, "R9 last cycle on time");
                end else if (b == 3 || b == NB - 1) begin
                    wait_until(r + 7);
                    push(r + 7, S_DRQ, 1, "R9 unserved");
                    wait_until(r + 8);
                    push(r + 8, S_DRQ, 0, "R9 slot end drop");
                    push(r + 8, S_LOST, 1, "R9 lost set");
                    push(r + 8, S_EOS, (b == NB - 1) ? 1 : 0, "R10 done on miss");
                end else begin
                    data_rd = 1'b1;
                    wait_until(r + 2);
                    push(r + 2, S_DRQ, 0, "R3 take");
                    push(r + 2, S_LOST, (b > 3) ? 1 : 0, "R9 sticky");
                end
            end
        end
        begin
            int r_end;
            r_end = k + 1 + GAP + NB * SLOT;
            wait_until(r_end);
            push(r_end, S_DRQ, 0, "R10 no extra byte");
            wait_until(r_end + 1);
            push(r_end + 1, S_DRQ, 0, "R10 stays low");
            push(r_end + 1, S_EOS, 0, "R10 done ended");
            wait_until(r_end + 2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1-R12 run: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_until(4);
        rst_n = 1'b1;
        wait_until(6);
        push(6, S_DRQ, 0, "R1 reset drq");
        push(6, S_IRQ, 0, "R1 reset irq");
        push(6, S_LOST, 0, "R1 reset lost");
        push(6, S_EOS, 0, "R1 reset done");
        data_rd = 1'b1; data_wr = 1'b1; irq_en = 1'b1;
        wait_until(8);
        push(8, S_DRQ, 0, "R12 idle strobes");
        push(8, S_IRQ, 0, "R1 idle irq");
        wait_until(10);
        run_sector(0);
        wait_until(cyc + 3);
        run_sector(1);
        wait_until(cyc + 3);
        run_sector(2);
        wait_until(cyc + 3);
        run_sector(0);
        wait_until(cyc + 3);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard R2: got %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule